// File: doc/BRIEF.md
# Shift and Rotate Unit with Flag Generation

This block is the shift datapath of an integer execution stage. It moves a destination operand left or right by a count in one pass and derives the condition flags from the outcome. It handles logical and arithmetic shifts, plain rotates, rotates that carry the incoming carry flag along as an extra operand bit, and double-width shifts that feed bits from a second source operand into the vacated end of the destination.

A caller presents an operation code, the operand pair, the count and the present carry flag, and raises `start_i` for one cycle. One clock later the block registers the new operand value and any new flag values. It raises `flag_we_o` for that cycle when the flags were written. A masked count of zero, an unused operation code, or a double shift whose count exceeds the operand width write back the destination unchanged and leave every flag alone.

The operand width `DATA_W` is 16 or 32.

Top module: `sru_shift_unit`

## Requirements
- R1: Only the low five bits of `cnt_i` count. A count of 33 acts as a count of 1, and a count of 32 acts as a count of 0.
- R2: With a masked count of zero, the next cycle shows `result_o` equal to the destination operand and `flag_we_o` low, and all five flags keep their values.
- R3: Left shifts (op 0 and op 1 behave identically) bring zeros in at bit 0. CF takes the last bit pushed past the top. For counts above the width, the result is zero and CF is 0.
- R4: The logical right shift (op 2) fills vacated top bits with zeros. The arithmetic right shift (op 3) fills them with copies of the sign bit. Both place the last bit pushed out of bit 0 in CF.
- R5: For a count of exactly 1, OF is set as follows. For a left shift it is the result's top bit XOR the new CF. For the logical right shift it is the original top bit. For the arithmetic right shift it is 0.
- R6: Rotate left (op 4) and rotate right (op 5) turn by the count modulo the width. CF equals result bit 0 after a left rotate and the top result bit after a right rotate. For a count of 1, OF is CF XOR the top bit (left) or the XOR of the top two result bits (right). SF, ZF and PF keep their values.
- R7: Rotate through carry left (op 6) and right (op 7) rotate the width+1 bit value made of `cf_i` above the operand, by the count modulo width+1. The new CF is that value's top bit. OF for a count of 1 follows the same formula as the plain rotate in the same direction. SF, ZF and PF are unchanged.
- R8: The double left shift (op 8) fills the low end from the source starting at the source's top bit. The double right shift (op 9) fills the high end from the source starting at its bit 0. CF takes the last destination bit shifted out. For a count of 1, OF is set when the top bit changed.
- R9: A double shift whose masked count exceeds `DATA_W` returns the destination unchanged and writes no flags.
- R10: Shifts and double shifts set SF to the result's top bit and ZF to 1 when the result is zero. They set PF to 1 when the low eight result bits hold an even number of ones.
- R11: For a count other than 1, OF keeps its value. `flag_we_o` is high only in the cycle after an accepted operation. Without `start_i`, all outputs hold.
- R12: Operation codes 10 to 15 return the destination unchanged and write no flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request strobe |
| op_i | input | 4 | Operation code (0..9 valid) |
| dst_i | input | DATA_W | Destination operand |
| src_i | input | DATA_W | Fill source for double shifts |
| cnt_i | input | CNT_W | Shift count, low five bits used |
| cf_i | input | 1 | Incoming carry flag |
| result_o | output | DATA_W | Registered result |
| cf_o | output | 1 | Carry flag |
| of_o | output | 1 | Overflow flag |
| sf_o | output | 1 | Sign flag |
| zf_o | output | 1 | Zero flag |
| pf_o | output | 1 | Parity flag (even parity of low byte) |
| flag_we_o | output | 1 | Flags written this cycle |

## Verification
The embedded properties watch the rules that can be stated cycle by cycle on every operation:
- zero-count and over-width requests change no flag;
- flags stay still whenever no write was signalled;
- SF, ZF and PF agree with the registered result after any shift;
- rotates leave those three flags alone;
- the single-step OF rules hold for the arithmetic right shift and the left rotate.

Only the directed scenarios can show that the bit movement itself is correct. That covers sign fill, carry-through rotation modulo width+1, the source bits entering a double shift in the right order, counts at and beyond the width, and the exact CF chosen in each case. These are compared against a step-by-step reference model in the bench.

// File: rtl/sru_pkg.sv
// Package: shared operation codes for the shift/rotate unit.
// Assumes a 4-bit operation field; codes 10..15 are unused.
package sru_pkg;

    typedef enum logic [3:0] {
        OP_SHL = 4'd0,
        OP_SAL = 4'd1,
        OP_SHR = 4'd2,
        OP_SAR = 4'd3,
        OP_ROL = 4'd4,
        OP_ROR = 4'd5,
        OP_RCL = 4'd6,
        OP_RCR = 4'd7,
        OP_DSL = 4'd8,
        OP_DSR = 4'd9
    } sru_op_e;

    localparam int CNT_MASK_W = 5;

endpackage

// File: rtl/sru_linear.sv
// Module: sru_linear
// Computes single-operand shifts (left, logical right, arithmetic right) and
// double-width shifts fed from a second source. Purely combinational.
// Assumes cnt is already masked to five bits; double shifts with a count
// above W are filtered out by the caller.
module sru_linear
    import sru_pkg::*;
#(
    parameter int W = 32
) (
    input  sru_op_e                 op,
    input  logic [W-1:0]            dst,
    input  logic [W-1:0]            src,
    input  logic [CNT_MASK_W-1:0]   cnt,
    output logic [W-1:0]            res,
    output logic                    cout,
    output logic                    ovf1
);

    logic [W:0]          shl_v;
    logic                fill;
    logic signed [W+1:0] shr_v;
    logic [2*W:0]        dsl_v;
    logic [2*W:0]        dsr_v;

    // Build all shifted candidates; the extra bit catches the last bit out.
    always_comb begin
        fill  = (op == OP_SAR) ? dst[W-1] : 1'b0;
        shl_v = {1'b0, dst} << cnt;
        shr_v = $signed({fill, dst, 1'b0}) >>> cnt;
        dsl_v = {1'b0, dst, src} << cnt;
        dsr_v = {src, dst, 1'b0} >> cnt;
    end

    // Select the candidate and the single-step overflow rule for this op.
    always_comb begin
        res  = dst;
        cout = 1'b0;
        ovf1 = 1'b0;
        case (op)
            OP_SHL, OP_SAL: begin
                res  = shl_v[W-1:0];
                cout = shl_v[W];
                ovf1 = shl_v[W-1] ^ shl_v[W];
            end
            OP_SHR, OP_SAR: begin
                res  = shr_v[W:1];
                cout = shr_v[0];
                ovf1 = (op == OP_SHR) ? dst[W-1] : 1'b0;
            end
            OP_DSL: begin
                res  = dsl_v[2*W-1:W];
                cout = dsl_v[2*W];
                ovf1 = dsl_v[2*W-1] ^ dst[W-1];
            end
            OP_DSR: begin
                res  = dsr_v[W:1];
                cout = dsr_v[0];
                ovf1 = dsr_v[W] ^ dst[W-1];
            end
            default: begin
                res  = dst;
                cout = 1'b0;
                ovf1 = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/sru_rotate.sv
// Module: sru_rotate
// Computes plain rotates (modulo W) and rotates through carry (modulo W+1).
// Purely combinational. Assumes W is a power of two and cnt is masked.
module sru_rotate
    import sru_pkg::*;
#(
    parameter int W = 32
) (
    input  sru_op_e                 op,
    input  logic [W-1:0]            dst,
    input  logic [CNT_MASK_W-1:0]   cnt,
    input  logic                    cin,
    output logic [W-1:0]            res,
    output logic                    cout,
    output logic                    ovf1
);

    localparam int LW = $clog2(W);
    localparam int RW = W + 1;

    logic [LW-1:0] rot_amt;
    logic [5:0]    rc_amt;
    logic [W-1:0]  rol_v;
    logic [W-1:0]  ror_v;
    logic [W:0]    rc_in;
    logic [W:0]    rcl_v;
    logic [W:0]    rcr_v;

    // Reduce the count for each rotate family.
    always_comb begin
        rot_amt = cnt[LW-1:0];
        rc_amt  = 6'(32'(cnt) % RW);
    end

    // Form the rotated candidates from two opposing shifts.
    always_comb begin
        rol_v = (dst << rot_amt) | (dst >> (W - int'(rot_amt)));
        ror_v = (dst >> rot_amt) | (dst << (W - int'(rot_amt)));
        rc_in = {cin, dst};
        rcl_v = (rc_in << rc_amt) | (rc_in >> (RW - int'(rc_amt)));
        rcr_v = (rc_in >> rc_amt) | (rc_in << (RW - int'(rc_amt)));
    end

    // Choose result, carry and single-step overflow per rotate kind.
    always_comb begin
        res  = dst;
        cout = cin;
        ovf1 = 1'b0;
        case (op)
            OP_ROL: begin
                res  = rol_v;
                cout = rol_v[0];
                ovf1 = rol_v[0] ^ rol_v[W-1];
            end
            OP_ROR: begin
                res  = ror_v;
                cout = ror_v[W-1];
                ovf1 = ror_v[W-1] ^ ror_v[W-2];
            end
            OP_RCL: begin
                res  = rcl_v[W-1:0];
                cout = rcl_v[W];
                ovf1 = rcl_v[W] ^ rcl_v[W-1];
            end
            OP_RCR: begin
                res  = rcr_v[W-1:0];
                cout = rcr_v[W];
                ovf1 = rcr_v[W-1] ^ rcr_v[W-2];
            end
            default: begin
                res  = dst;
                cout = cin;
                ovf1 = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/sru_flagcalc.sv
// Module: sru_flagcalc
// Derives sign, zero and parity from a result word. Parity covers the low
// byte (or the whole word if narrower) and is 1 for an even count of ones.
module sru_flagcalc #(
    parameter int W = 32
) (
    input  logic [W-1:0] res,
    output logic         sf,
    output logic         zf,
    output logic         pf
);

    localparam int PW = (W < 8) ? W : 8;

    // Result-derived status bits.
    always_comb begin
        sf = res[W-1];
        zf = ~|res;
        pf = ~^res[PW-1:0];
    end

endmodule

// File: rtl/sru_shift_unit.sv
// Module: sru_shift_unit (top)
// Shift/rotate execution unit with registered result and flags. A request is
// taken when start_i is high; outputs update on the following clock edge.
// Assumes DATA_W is 16 or 32. Zero masked counts, unused op codes and
// over-width double shifts write the destination back and leave flags alone.
module sru_shift_unit
    import sru_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [3:0]        op_i,
    input  logic [DATA_W-1:0] dst_i,
    input  logic [DATA_W-1:0] src_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              cf_i,
    output logic [DATA_W-1:0] result_o,
    output logic              cf_o,
    output logic              of_o,
    output logic              sf_o,
    output logic              zf_o,
    output logic              pf_o,
    output logic              flag_we_o
);

    sru_op_e                 op;
    logic [CNT_MASK_W-1:0]   masked;
    logic                    cnt_unused;
    logic                    is_lin;
    logic                    is_rot;
    logic                    is_dbl;
    logic                    cnt_zero;
    logic                    cnt_one;
    logic                    dbl_over;
    logic                    upd;

    logic [DATA_W-1:0] lin_res, rot_res, new_res;
    logic              lin_c, rot_c, new_c;
    logic              lin_o, rot_o, new_o;
    logic              new_sf, new_zf, new_pf;

    logic [DATA_W-1:0] result_q;
    logic              cf_q, of_q, sf_q, zf_q, pf_q, we_q;

    // Count masking; upper count bits are deliberately ignored.
    always_comb begin
        op         = sru_op_e'(op_i);
        masked     = cnt_i[CNT_MASK_W-1:0];
        cnt_unused = ^cnt_i[CNT_W-1:CNT_MASK_W];
        cnt_zero   = (masked == '0);
        cnt_one    = (masked == CNT_MASK_W'(1));
    end

    // Operation class decode.
    always_comb begin
        is_lin = 1'b0;
        is_rot = 1'b0;
        is_dbl = 1'b0;
        case (op)
            OP_SHL, OP_SAL, OP_SHR, OP_SAR: is_lin = 1'b1;
            OP_ROL, OP_ROR, OP_RCL, OP_RCR: is_rot = 1'b1;
            OP_DSL, OP_DSR: begin
                is_lin = 1'b1;
                is_dbl = 1'b1;
            end
            default: ;
        endcase
    end

    // Over-width double shift only exists when the count can exceed DATA_W.
    generate
        if (DATA_W < (1 << CNT_MASK_W) - 1) begin : g_dbl_limit
            assign dbl_over = is_dbl && ({1'b0, masked} > (CNT_MASK_W + 1)'(DATA_W));
        end else begin : g_dbl_nolimit
            assign dbl_over = 1'b0;
        end
    endgenerate

    assign upd = start_i && (is_lin || is_rot) && !cnt_zero && !dbl_over;

    sru_linear #(.W(DATA_W)) u_linear (
        .op   (op),
        .dst  (dst_i),
        .src  (src_i),
        .cnt  (masked),
        .res  (lin_res),
        .cout (lin_c),
        .ovf1 (lin_o)
    );

    sru_rotate #(.W(DATA_W)) u_rotate (
        .op   (op),
        .dst  (dst_i),
        .cnt  (masked),
        .cin  (cf_i),
        .res  (rot_res),
        .cout (rot_c),
        .ovf1 (rot_o)
    );

    // Merge the two datapaths by operation class.
    always_comb begin
        new_res = is_rot ? rot_res : lin_res;
        new_c   = is_rot ? rot_c   : lin_c;
        new_o   = is_rot ? rot_o   : lin_o;
    end

    sru_flagcalc #(.W(DATA_W)) u_flags (
        .res (new_res),
        .sf  (new_sf),
        .zf  (new_zf),
        .pf  (new_pf)
    );

    // Result, flag and write-enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
            cf_q     <= 1'b0;
            of_q     <= 1'b0;
            sf_q     <= 1'b0;
            zf_q     <= 1'b0;
            pf_q     <= 1'b0;
            we_q     <= 1'b0;
        end else begin
            we_q <= upd;
            if (start_i) begin
                result_q <= upd ? new_res : dst_i;
            end
            if (upd) begin
                cf_q <= new_c;
                if (cnt_one) begin
                    of_q <= new_o;
                end
                if (is_lin) begin
                    sf_q <= new_sf;
                    zf_q <= new_zf;
                    pf_q <= new_pf;
                end
            end
        end
    end

    assign result_o  = result_q;
    assign cf_o      = cf_q;
    assign of_o      = of_q;
    assign sf_o      = sf_q;
    assign zf_o      = zf_q;
    assign pf_o      = pf_q;
    assign flag_we_o = we_q;

    // R2: zero count writes the destination back and no flags.
    p_zero_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && cnt_zero) |=> (!flag_we_o && result_o == $past(dst_i)));

    // R9: over-width double shift behaves as a no-op.
    p_dbl_over_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && dbl_over) |=> (!flag_we_o && result_o == $past(dst_i)));

    // R11: flags move only in a cycle that signals a write.
    p_flags_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_we_o |-> $stable({cf_o, of_o, sf_o, zf_o, pf_o}));

    // R11: a write indication always follows a request.
    p_we_after_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we_o |-> $past(start_i));

    // R10: status flags agree with the registered result after a shift.
    p_lin_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && is_lin) |=> (zf_o == (result_o == '0) && sf_o == result_o[DATA_W-1]
                             && pf_o == ~^result_o[7:0]));

    // R6: rotates leave sign, zero and parity alone.
    p_rot_keeps_szp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && is_rot) |=> $stable({sf_o, zf_o, pf_o}));

    // R5: single-step arithmetic right shift clears OF.
    p_sar_of_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && op == OP_SAR && cnt_one) |=> !of_o);

    // R6: single-step left rotate OF equals CF xor top result bit.
    p_rol_of_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && op == OP_ROL && cnt_one) |=> (of_o == (cf_o ^ result_o[DATA_W-1])));

endmodule

// File: tb/sru_shift_unit_test.sv
`timescale 1ns/1ps
module sru_shift_unit_test;

    localparam int W = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start_i;
    logic [3:0]    op_i;
    logic [W-1:0]  dst_i, src_i;
    logic [7:0]    cnt_i;
    logic          cf_i;
    logic [W-1:0]  result_o;
    logic          cf_o, of_o, sf_o, zf_o, pf_o, flag_we_o;

    int checks = 0;
    int errors = 0;

    // Reference model state.
    logic [W-1:0] m_res;
    logic         m_cf, m_of, m_sf, m_zf, m_pf, m_we;

    always #10 clk = ~clk;

    sru_shift_unit #(.DATA_W(W), .CNT_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
        .dst_i(dst_i), .src_i(src_i), .cnt_i(cnt_i), .cf_i(cf_i),
        .result_o(result_o), .cf_o(cf_o), .of_o(of_o), .sf_o(sf_o),
        .zf_o(zf_o), .pf_o(pf_o), .flag_we_o(flag_we_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Step-by-step model built from the requirements.
    task automatic model(input logic [3:0] op, input logic [W-1:0] dst, input logic [W-1:0] src,
                         input logic [7:0] cnt, input logic cin);
        int n;
        logic [W-1:0] d, s;
        logic c, t, dbl, lin, rot;
        n   = int'(cnt[4:0]);
        dbl = (op == 4'd8) || (op == 4'd9);
        lin = (op <= 4'd3) || dbl;
        rot = (op >= 4'd4) && (op <= 4'd7);
        m_we  = 1'b0;
        m_res = dst;
        if (!(lin || rot) || n == 0 || (dbl && n > W)) return;
        d = dst; s = src; c = cin;
        for (int i = 0; i < n; i++) begin
            case (op)
                4'd0, 4'd1: begin c = d[W-1]; d = {d[W-2:0], 1'b0}; end
                4'd2: begin c = d[0]; d = {1'b0, d[W-1:1]}; end
                4'd3: begin c = d[0]; d = {d[W-1], d[W-1:1]}; end
                4'd4: begin c = d[W-1]; d = {d[W-2:0], d[W-1]}; end
                4'd5: begin c = d[0]; d = {d[0], d[W-1:1]}; end
                4'd6: begin t = d[W-1]; d = {d[W-2:0], c}; c = t; end
                4'd7: begin t = d[0]; d = {c, d[W-1:1]}; c = t; end
                4'd8: begin c = d[W-1]; d = {d[W-2:0], s[W-1]}; s = s << 1; end
                default: begin c = d[0]; d = {s[0], d[W-1:1]}; s = s >> 1; end
            endcase
        end
        m_res = d; m_we = 1'b1; m_cf = c;
        if (n == 1) begin
            case (op)
                4'd0, 4'd1, 4'd4, 4'd6: m_of = d[W-1] ^ c;
                4'd2: m_of = dst[W-1];
                4'd3: m_of = 1'b0;
                4'd5, 4'd7: m_of = d[W-1] ^ d[W-2];
                default: m_of = d[W-1] ^ dst[W-1];
            endcase
        end
        if (lin) begin
            m_sf = d[W-1];
            m_zf = (d == '0);
            m_pf = ~^d[7:0];
        end
    endtask

    // Issue one request, then compare every output with the model.
    task automatic do_op(input string tag, input logic [3:0] op, input logic [W-1:0] dst,
                         input logic [W-1:0] src, input logic [7:0] cnt, input logic cin);
        @(negedge clk);
        op_i = op; dst_i = dst; src_i = src; cnt_i = cnt; cf_i = cin; start_i = 1'b1;
        model(op, dst, src, cnt, cin);
        @(negedge clk);
        start_i = 1'b0;
        chk({tag, " result"}, 32'(result_o), 32'(m_res));
        chk({tag, " cf"}, 32'(cf_o), 32'(m_cf));
        chk({tag, " of"}, 32'(of_o), 32'(m_of));
        chk({tag, " sf"}, 32'(sf_o), 32'(m_sf));
        chk({tag, " zf"}, 32'(zf_o), 32'(m_zf));
        chk({tag, " pf"}, 32'(pf_o), 32'(m_pf));
        chk({tag, " we"}, 32'(flag_we_o), 32'(m_we));
    endtask

    task automatic t_reset();
        chk("reset result", 32'(result_o), 32'h0);
        chk("reset flags", 32'({cf_o, of_o, sf_o, zf_o, pf_o}), 32'h0);
        chk("reset we", 32'(flag_we_o), 32'h0);
        m_res = '0; m_cf = 0; m_of = 0; m_sf = 0; m_zf = 0; m_pf = 0; m_we = 0;
    endtask

    task automatic t_left();
        do_op("R3 shl4", 4'd0, 16'h00F0, 16'h0, 8'd4, 1'b0);
        chk("R3 shl4 hand", 32'(result_o), 32'h0F00);
        do_op("R5 shl1 ovf", 4'd1, 16'h4001, 16'h0, 8'd1, 1'b0);
        chk("R5 shl1 of hand", 32'(of_o), 32'h1);
        do_op("R3 shl16", 4'd0, 16'h8001, 16'h0, 8'd16, 1'b0);
        chk("R3 shl16 cf hand", 32'(cf_o), 32'h1);
        do_op("R3 shl20", 4'd1, 16'hFFFF, 16'h0, 8'd20, 1'b0);
        do_op("R10 shl parity", 4'd0, 16'h0003, 16'h0, 8'd2, 1'b0);
    endtask

    task automatic t_right();
        do_op("R4 sar3", 4'd3, 16'h8000, 16'h0, 8'd3, 1'b0);
        chk("R4 sar3 hand", 32'(result_o), 32'hF000);
        do_op("R5 sar1", 4'd3, 16'hC001, 16'h0, 8'd1, 1'b0);
        do_op("R5 shr1", 4'd2, 16'h8003, 16'h0, 8'd1, 1'b0);
        chk("R5 shr1 of hand", 32'(of_o), 32'h1);
        do_op("R4 shr5", 4'd2, 16'hF0F0, 16'h0, 8'd5, 1'b0);
        do_op("R4 sar31", 4'd3, 16'h8421, 16'h0, 8'd31, 1'b0);
        do_op("R11 of kept", 4'd2, 16'h1234, 16'h0, 8'd3, 1'b0);
    endtask

    task automatic t_rotate();
        do_op("R6 rol1", 4'd4, 16'h8001, 16'h0, 8'd1, 1'b0);
        chk("R6 rol1 hand", 32'(result_o), 32'h0003);
        do_op("R6 ror1", 4'd5, 16'h0001, 16'h0, 8'd1, 1'b0);
        do_op("R6 rol16", 4'd4, 16'hA5C3, 16'h0, 8'd16, 1'b0);
        do_op("R6 ror7", 4'd5, 16'h1357, 16'h0, 8'd7, 1'b1);
        do_op("R7 rcl1", 4'd6, 16'h4000, 16'h0, 8'd1, 1'b1);
        do_op("R7 rcr1", 4'd7, 16'h0001, 16'h0, 8'd1, 1'b1);
        chk("R7 rcr1 hand", 32'(result_o), 32'h8000);
        do_op("R7 rcl17", 4'd6, 16'h1234, 16'h0, 8'd17, 1'b1);
        do_op("R7 rcr9", 4'd7, 16'hBEEF, 16'h0, 8'd9, 1'b0);
    endtask

    task automatic t_double();
        do_op("R8 dsl4", 4'd8, 16'h1234, 16'hABCD, 8'd4, 1'b0);
        chk("R8 dsl4 hand", 32'(result_o), 32'h234A);
        do_op("R8 dsr4", 4'd9, 16'h1234, 16'hABCD, 8'd4, 1'b0);
        chk("R8 dsr4 hand", 32'(result_o), 32'hD123);
        do_op("R8 dsl1", 4'd8, 16'h4000, 16'h0000, 8'd1, 1'b0);
        do_op("R8 dsr16", 4'd9, 16'h8000, 16'h5A5A, 8'd16, 1'b0);
        do_op("R9 dsl17", 4'd8, 16'h0F0F, 16'hFFFF, 8'd17, 1'b1);
        do_op("R9 dsr31", 4'd9, 16'h00FF, 16'hFFFF, 8'd31, 1'b0);
    endtask

    task automatic t_mask();
        do_op("R1 shl33", 4'd0, 16'h4001, 16'h0, 8'd33, 1'b0);
        chk("R1 shl33 hand", 32'(result_o), 32'h8002);
        do_op("R2 cnt0", 4'd2, 16'h7777, 16'h0, 8'd0, 1'b1);
        do_op("R2 cnt32", 4'd4, 16'h0001, 16'h0, 8'd32, 1'b0);
        do_op("R12 op12", 4'd12, 16'hCAFE, 16'h0, 8'd3, 1'b1);
        do_op("R12 op15", 4'd15, 16'h0000, 16'h0, 8'd1, 1'b0);
    endtask

    task automatic t_hold();
        do_op("R11 setup", 4'd0, 16'h0101, 16'h0, 8'd1, 1'b0);
        @(negedge clk);
        op_i = 4'd3; dst_i = 16'hFFFF; cnt_i = 8'd2; cf_i = 1'b1; start_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R11 hold result", 32'(result_o), 32'(m_res));
        chk("R11 hold flags", 32'({cf_o, of_o, sf_o, zf_o, pf_o}),
            32'({m_cf, m_of, m_sf, m_zf, m_pf}));
        chk("R11 hold we", 32'(flag_we_o), 32'h0);
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start_i = 1'b0; op_i = '0; dst_i = '0; src_i = '0; cnt_i = '0; cf_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_left();
        t_right();
        t_rotate();
        t_double();
        t_mask();
        t_hold();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule